// File: doc/BRIEF.md
# Grouped Interrupt Expansion Controller

This block fans a large number of peripheral interrupt lines into a small set of CPU interrupt lines. Sources are arranged in groups of eight. Every source owns a sticky pending bit and an enable bit. Every group owns one blocking bit, set when the group signals the CPU. While that bit is set, the group cannot signal again. Software releases it by writing 1.

The group line to the CPU is a one-cycle pulse. The CPU later asks for a vector and names a group. The block answers from the pending and enable state present at that moment, not from the state at the time of the pulse. The answer is the winning source of highest priority, and a pending bit that arrives after the pulse can still overtake an earlier one. The winning pending bit is cleared as the vector is returned. If no source qualifies, a fixed spurious vector is returned instead.

Top module: `irq_group_expander`

## Requirements
- R1: A rising edge on a source input sets that source's pending bit on the next clock edge, whether or not the source is enabled. Pending bits are read with register selector 0, where bit s is source s.
- R2: A pending bit stays set until a vector fetch selects it. A pending bit whose enable is clear is never cleared.
- R3: A group emits a single-cycle pulse on its CPU line only when at least one of its sources is both pending and enabled (selector 1, bit s) and its blocking bit is clear.
- R4: The blocking bit is set on the same clock edge that the group's pulse rises. It is read as bit 0 with selector 2.
- R5: While a group's blocking bit is set, the group emits no pulse, whatever new sources become pending.
- R6: Writing selector 2 with bit 0 = 1 clears the blocking bit. Writing it with bit 0 = 0 has no effect. If the group still has sources that are pending and enabled, it pulses one cycle after the clear.
- R7: A vector fetch returns, one cycle after the request, the value base + (group×8 + s)×2. Here s is the lowest-numbered source in the fetched group that is pending and enabled at fetch time. Source 0 has the highest priority.
- R8: A fetch clears only the pending bit of the source it selected.
- R9: If a new edge on a source lands in the same cycle as the fetch that clears that source, the pending bit stays set.
- R10: A fetch returns the spurious vector and changes no pending bit in two cases: when no source of the group is pending and enabled, and when the group number is 12 or higher.
- R11: After reset, all pending, enable and blocking bits read 0, no pulse is driven and no vector is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_irq_i | input | 96 | Source request lines, group g source s at bit g*8+s |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | {selector[1:0], group[3:0]}; selector 0 pending, 1 enable, 2 blocking, 3 reads 0 |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from the address |
| vec_req_i | input | 1 | Vector fetch request |
| vec_grp_i | input | 4 | Group being fetched |
| vec_valid_o | output | 1 | Vector valid, one cycle after the request |
| vec_addr_o | output | 16 | Vector address |
| grp_pulse_o | output | 12 | Per-group request pulse toward the CPU |

## Verification
Two operations can act on the same pending bit in one cycle: a new edge on a source, which sets the bit, and a fetch that selects that source, which clears it. The bench raises the source edge on the same falling edge that starts the fetch. It expects the vector of that source, and it expects the pending bit to read as still set afterwards. A second fetch must then return the same source again. The bench also checks a case where a blocking-bit release meets pending sources, and the pulse count must rise by exactly one.

// File: rtl/irq_group_pkg.sv
// Package: shared register selector encoding for the grouped interrupt expander.
// Assumes a 2-bit selector in the upper address bits.
package irq_group_pkg;
    typedef enum logic [1:0] {
        SEL_PENDING = 2'd0,
        SEL_ENABLE  = 2'd1,
        SEL_BLOCK   = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_edge_catch.sv
// Module: irq_edge_catch
// Turns level source lines into one-cycle set events on their rising edge.
// Assumes the inputs are already synchronous to clk.
module irq_edge_catch #(
    parameter int WIDTH = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] lvl_q;

    // Remember the previous level of every line.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_i;
    end

    // A set event is a line that is high now and was low one cycle before.
    always_comb rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/irq_group_slice.sv
// Module: irq_group_slice
// Holds the pending, enable and blocking state of one group and drives its
// CPU pulse. Assumes the clear mask has at most one bit set.
module irq_group_slice #(
    parameter int SRC = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SRC-1:0] set_i,
    input  logic [SRC-1:0] clr_i,
    input  logic           en_we_i,
    input  logic [SRC-1:0] en_wdata_i,
    input  logic           blk_clr_i,
    output logic [SRC-1:0] pend_o,
    output logic [SRC-1:0] en_o,
    output logic           blk_o,
    output logic [SRC-1:0] live_o,
    output logic           pulse_o
);
    logic [SRC-1:0] pend_q;
    logic [SRC-1:0] en_q;
    logic           blk_q;
    logic           pulse_q;
    logic           fire;

    // Sources that could win a fetch, and whether the group may signal now.
    always_comb begin
        live_o = pend_q & en_q;
        fire   = (|live_o) && !blk_q;
    end

    // Pending bits: the clear from a fetch applies first, then new edges set.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | set_i;
    end

    // Enable bits are written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_we_i) en_q <= en_wdata_i;
    end

    // The blocking bit is set when the group signals, and cleared by a write of 1.
    always_ff @(posedge clk) begin
        if (!rst_n)         blk_q <= 1'b0;
        else if (fire)      blk_q <= 1'b1;
        else if (blk_clr_i) blk_q <= 1'b0;
    end

    // The CPU line is a registered single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= fire;
    end

    assign pend_o  = pend_q;
    assign en_o    = en_q;
    assign blk_o   = blk_q;
    assign pulse_o = pulse_q;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(pend_q) & ~$past(clr_i)) & ~pend_q) == '0)); // R2
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(set_i) & ~pend_q) == '0)); // R9
    AST_PULSE_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> $past(|(pend_q & en_q))); // R3
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q); // R3
    AST_BLOCK_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> blk_q); // R4
    AST_NO_PULSE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> !$past(blk_q)); // R5
    AST_BLOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(blk_q) && !$past(blk_clr_i)) |-> blk_q); // R6
endmodule

// File: rtl/irq_prio_pick.sv
// Module: irq_prio_pick
// Fixed-priority picker: the lowest set index wins. Purely combinational.
module irq_prio_pick #(
    parameter int SRC = 8,
    localparam int IDX_W = (SRC > 1) ? $clog2(SRC) : 1
) (
    input  logic [SRC-1:0]   cand_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan from the lowest priority upward so that the lowest index is kept last.
    always_comb begin
        found_o = |cand_i;
        idx_o   = '0;
        for (int i = SRC - 1; i >= 0; i--) begin
            if (cand_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_group_expander.sv
// Module: irq_group_expander (top)
// Expands NUM_GROUPS x SRC_PER_GRP sources onto NUM_GROUPS CPU pulse lines.
// Vectors are decoded when fetched, from the live pending and enable state.
// Assumes the CPU issues at most one fetch per cycle.
module irq_group_expander
    import irq_group_pkg::*;
#(
    parameter int NUM_GROUPS   = 12,
    parameter int SRC_PER_GRP  = 8,
    parameter int VEC_W        = 16,
    parameter logic [VEC_W-1:0] VEC_BASE = 16'h0100,
    parameter logic [VEC_W-1:0] VEC_SPUR = 16'h00FE,
    localparam int NSRC   = NUM_GROUPS * SRC_PER_GRP,
    localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int IDX_W  = (SRC_PER_GRP > 1) ? $clog2(SRC_PER_GRP) : 1,
    localparam int ADDR_W = GRP_W + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        src_irq_i,
    input  logic                   reg_we_i,
    input  logic [ADDR_W-1:0]      reg_addr_i,
    input  logic [SRC_PER_GRP-1:0] reg_wdata_i,
    output logic [SRC_PER_GRP-1:0] reg_rdata_o,
    input  logic                   vec_req_i,
    input  logic [GRP_W-1:0]       vec_grp_i,
    output logic                   vec_valid_o,
    output logic [VEC_W-1:0]       vec_addr_o,
    output logic [NUM_GROUPS-1:0]  grp_pulse_o
);
    localparam logic [VEC_W-1:0] VEC_TOP = VEC_BASE + VEC_W'(NSRC * 2);

    logic [NSRC-1:0]                          rise;
    logic [NUM_GROUPS-1:0][SRC_PER_GRP-1:0]   pend;
    logic [NUM_GROUPS-1:0][SRC_PER_GRP-1:0]   en;
    logic [NUM_GROUPS-1:0][SRC_PER_GRP-1:0]   live;
    logic [NUM_GROUPS-1:0][SRC_PER_GRP-1:0]   clr;
    logic [NUM_GROUPS-1:0]                    blk;
    reg_sel_e                                 sel;
    logic [GRP_W-1:0]                         reg_grp;
    logic [SRC_PER_GRP-1:0]                   cand;
    logic                                     found;
    logic [IDX_W-1:0]                         idx;
    logic [VEC_W-1:0]                         vec_nx;
    logic                                     vec_valid_q;
    logic [VEC_W-1:0]                         vec_addr_q;

    // Split the register address into selector and group.
    always_comb begin
        sel     = reg_sel_e'(reg_addr_i[ADDR_W-1 -: 2]);
        reg_grp = reg_addr_i[GRP_W-1:0];
    end

    irq_edge_catch #(.WIDTH(NSRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (src_irq_i),
        .rise_o (rise)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic hit;
        logic en_we;
        logic blk_clr;

        // Decode register writes aimed at this group.
        always_comb begin
            hit     = (reg_grp == GRP_W'(g));
            en_we   = reg_we_i && hit && (sel == SEL_ENABLE);
            blk_clr = reg_we_i && hit && (sel == SEL_BLOCK) && reg_wdata_i[0];
        end

        // Clear only the winner of a fetch that targets this group.
        always_comb begin
            clr[g] = '0;
            if (vec_req_i && found && (vec_grp_i == GRP_W'(g)))
                clr[g][idx] = 1'b1;
        end

        irq_group_slice #(.SRC(SRC_PER_GRP)) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (rise[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .clr_i      (clr[g]),
            .en_we_i    (en_we),
            .en_wdata_i (reg_wdata_i),
            .blk_clr_i  (blk_clr),
            .pend_o     (pend[g]),
            .en_o       (en[g]),
            .blk_o      (blk[g]),
            .live_o     (live[g]),
            .pulse_o    (grp_pulse_o[g])
        );
    end

    // Register read mux; unknown groups and the spare selector read as zero.
    always_comb begin
        reg_rdata_o = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (reg_grp == GRP_W'(g)) begin
                case (sel)
                    SEL_PENDING: reg_rdata_o = pend[g];
                    SEL_ENABLE:  reg_rdata_o = en[g];
                    SEL_BLOCK:   reg_rdata_o = SRC_PER_GRP'(blk[g]);
                    default:     reg_rdata_o = '0;
                endcase
            end
        end
    end

    // Candidate sources of the fetched group; an out-of-range group has none.
    always_comb begin
        cand = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (vec_grp_i == GRP_W'(g)) cand = live[g];
        end
    end

    irq_prio_pick #(.SRC(SRC_PER_GRP)) u_pick (
        .cand_i  (cand),
        .found_o (found),
        .idx_o   (idx)
    );

    // Vector arithmetic: base plus twice the flat source number.
    always_comb begin
        if (found)
            vec_nx = VEC_BASE + VEC_W'((int'(vec_grp_i) * SRC_PER_GRP + int'(idx)) * 2);
        else
            vec_nx = VEC_SPUR;
    end

    // Register the fetch answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid_q <= 1'b0;
            vec_addr_q  <= '0;
        end else begin
            vec_valid_q <= vec_req_i;
            if (vec_req_i) vec_addr_q <= vec_nx;
        end
    end

    assign vec_valid_o = vec_valid_q;
    assign vec_addr_o  = vec_addr_q;

    AST_VEC_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_q |-> $past(vec_req_i)); // R7
    AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_q && vec_addr_q != VEC_SPUR) |->
        (vec_addr_q >= VEC_BASE && vec_addr_q < VEC_TOP && vec_addr_q[0] == 1'b0)); // R7
    AST_PICK_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> cand[idx]); // R7
    AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr)); // R8
    AST_CLEAR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr) |-> (vec_req_i && found)); // R10
endmodule

// File: tb/tb_irq_group_expander.sv
// Scoreboard bench: fetch tasks queue expected vectors, a monitor pops them.
module tb_irq_group_expander;
    localparam int NG   = 12;
    localparam int NS   = 8;
    localparam int BASE = 'h0100;
    localparam int SPUR = 'h00FE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src_irq = '0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        vec_req = 1'b0;
    logic [3:0]  vec_grp = '0;
    logic        vec_valid;
    logic [15:0] vec_addr;
    logic [11:0] grp_pulse;

    int n_chk = 0;
    int n_fail = 0;
    int pulse_cnt [NG];
    logic [7:0] m_pend [NG];
    logic [7:0] m_en   [NG];
    int exp_q [$];
    bit done = 0;

    always #4 clk = ~clk;

    irq_group_expander dut (
        .clk(clk), .rst_n(rst_n), .src_irq_i(src_irq),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .vec_req_i(vec_req), .vec_grp_i(vec_grp),
        .vec_valid_o(vec_valid), .vec_addr_o(vec_addr), .grp_pulse_o(grp_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: count pulses and compare returned vectors with the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int g = 0; g < NG; g++) pulse_cnt[g] += int'(grp_pulse[g]);
            if (vec_valid) begin
                if (exp_q.size() == 0) chk("R7 unexpected vector", int'(vec_addr), -1);
                else chk("R7/R10 vector", int'(vec_addr), exp_q.pop_front());
            end
        end
    end

    function automatic int expect_vec(input int g);
        if (g >= NG) return SPUR;
        for (int s = 0; s < NS; s++)
            if (m_pend[g][s] && m_en[g][s]) return BASE + (g * NS + s) * 2;
        return SPUR;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input int sel, input int g, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = {2'(sel), 4'(g)}; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
        if (sel == 1 && g < NG) m_en[g] = d;
    endtask

    task automatic rd(input int sel, input int g, output int d);
        reg_addr = {2'(sel), 4'(g)};
        #1 d = int'(reg_rdata);
    endtask

    task automatic raise(input int g, input logic [7:0] mask);
        @(negedge clk);
        src_irq[g*NS +: NS] = mask;
        m_pend[g] |= mask;
        @(negedge clk);
        src_irq[g*NS +: NS] = '0;
    endtask

    // Driver: push the expected vector, then issue the fetch.
    task automatic fetch(input int g, input logic [7:0] coinc);
        int e;
        e = expect_vec(g);
        exp_q.push_back(e);
        @(negedge clk);
        vec_req = 1; vec_grp = 4'(g);
        if (g < NG) src_irq[g*NS +: NS] = coinc;
        if (e != SPUR) m_pend[g][(e - BASE) / 2 - g * NS] = 1'b0;
        if (g < NG) m_pend[g] |= coinc;
        @(negedge clk);
        vec_req = 0;
        if (g < NG) src_irq[g*NS +: NS] = '0;
    endtask

    initial begin
        int d;
        int p;
        for (int g = 0; g < NG; g++) begin
            pulse_cnt[g] = 0; m_pend[g] = '0; m_en[g] = '0;
        end
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R11 reset state
        rd(0, 0, d);  chk("R11 pending g0", d, 0);
        rd(0, 11, d); chk("R11 pending g11", d, 0);
        rd(1, 0, d);  chk("R11 enable g0", d, 0);
        rd(2, 0, d);  chk("R11 block g0", d, 0);
        chk("R11 pulses", int'(grp_pulse), 0);
        chk("R11 vec_valid", int'(vec_valid), 0);
        // R1 pending set while disabled, no pulse
        raise(0, 8'h08);
        cyc(2);
        rd(0, 0, d); chk("R1 pending latched", d, 'h08);
        chk("R3 no pulse while disabled", pulse_cnt[0], 0);
        // R3/R4 enable -> one pulse and blocking bit set
        wr(1, 0, 8'h08);
        cyc(3);
        chk("R3 one pulse", pulse_cnt[0], 1);
        rd(2, 0, d); chk("R4 block set", d, 1);
        // R5 new enabled source while blocked
        wr(1, 0, 8'h48);
        raise(0, 8'h40);
        cyc(3);
        chk("R5 no pulse while blocked", pulse_cnt[0], 1);
        // R7 later higher-priority source wins
        wr(1, 0, 8'h4A);
        raise(0, 8'h02);
        fetch(0, 8'h00);
        cyc(1);
        rd(0, 0, d); chk("R8 only winner cleared", d, 'h48);
        // R6 write 0 ignored, write 1 releases and re-pulses
        wr(2, 0, 8'h00);
        cyc(2);
        rd(2, 0, d); chk("R6 write0 no effect", d, 1);
        chk("R6 no pulse on write0", pulse_cnt[0], 1);
        wr(2, 0, 8'h01);
        cyc(2);
        chk("R6 re-pulse after release", pulse_cnt[0], 2);
        rd(2, 0, d); chk("R6 block set again", d, 1);
        fetch(0, 8'h00);
        fetch(0, 8'h00);
        fetch(0, 8'h00);   // R10 nothing left
        cyc(1);
        rd(0, 0, d); chk("R8 group 0 drained", d, 0);
        // R2 disabled pending kept
        wr(1, 5, 8'h80);
        raise(5, 8'h81);
        fetch(5, 8'h00);
        fetch(5, 8'h00);   // R10 spurious, disabled bit kept
        cyc(1);
        rd(0, 5, d); chk("R2 disabled pending kept", d, 'h01);
        // R9 set and clear in the same cycle
        wr(1, 7, 8'hFF);
        raise(7, 8'h10);
        fetch(7, 8'h10);
        cyc(1);
        rd(0, 7, d); chk("R9 set wins over clear", d, 'h10);
        fetch(7, 8'h00);
        cyc(1);
        rd(0, 7, d); chk("R9 cleared by later fetch", d, 0);
        // R10 out-of-range group
        fetch(13, 8'h00);
        cyc(1);
        rd(0, 5, d); chk("R10 out-of-range no change", d, 'h01);
        // R7 full priority sweep
        wr(1, 11, 8'hFF);
        raise(11, 8'hFF);
        for (int k = 0; k < NS; k++) fetch(11, 8'h00);
        cyc(2);
        rd(0, 11, d); chk("R7 sweep drained", d, 0);
        p = pulse_cnt[11];
        chk("R3 group 11 single pulse", p, 1);
        chk("R7 queue empty", exp_q.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule